// File: doc/BRIEF.md
# PLL Bring-up and Lock Retry Sequencer

This block brings a clock-synthesis PLL up from cold with no software in the loop. A start pulse enables the PLL bias circuit and waits a fixed time. The block then holds the PLL in reset and writes the auxiliary configuration words over a simple write bus. It writes the main control word, which sets the enable and reset flags and the divider fields derived from a target frequency. It then releases reset, lets the loop settle for a fixed number of microsecond ticks, and samples the lock input.

A missed lock is counted and the reset, program and release sequence runs again from the start. The bias step is not repeated. Once lock is seen the count clears and the block reports done. If the count reaches the retry limit, the block raises a system-reset request and halts until its own reset. Time is measured only in `us_tick` pulses, so the same netlist works at any core clock.

Top module: `pll_bringup_seq`

## Requirements
- R1: Out of reset, `bandgap_en`, `pll_rst`, `pll_en`, `cfg_wr`, `done`, `sys_rst_req` are 0 and `fail_cnt` is 0.
- R2: A `start` pulse sets `bandgap_en`, which then stays high. At least BANDGAP_US (default 100) `us_tick` pulses pass before `pll_rst` first rises.
- R3: Each attempt asserts `pll_rst` and then writes the auxiliary words in index order. Word i is taken from `aux_cfg[32*i +: 32]` and sent with `cfg_sel` = i+1. The main word follows with `cfg_sel` = 0. `pll_rst` stays high through every write and falls after the main word. `cfg_wr` is never high while `pll_rst` is low.
- R4: The main word carries bit 30 (enable) = 1, bit 29 (reset) = 1 and bit 31 (lock status, read-only) = 0. The fields are M in [8:0], N in [13:9] and OD in [17:16], giving 24 MHz / N × M / 2^OD.
- R5: For a target of 600..1200 MHz the fields are OD=1, N=1, M=target/12. For a target of 1201..2000 MHz they are OD=0, N=1, M=target/24. Any other target gives zero in M, N and OD.
- R6: `pll_lock` is sampled only after SETTLE_US (default 20) ticks have passed since reset was released. A lock that is already present earlier does not end the wait.
- R7: A low lock at the sample point increments `fail_cnt` by one and repeats the whole sequence of R3, without repeating the bias wait.
- R8: A high lock at the sample point sets `done`, clears `fail_cnt` to 0 and leaves `pll_rst` low and `pll_en` high.
- R9: When `fail_cnt` reaches RETRY_LIMIT (default 8), `sys_rst_req` rises and stays high until reset. After that no further writes occur and `start` is ignored.
- R10: A `start` pulse while the block is done reruns the sequence from the bias wait. A `start` pulse during a sequence has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to bring the PLL up |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| target_mhz | input | TGT_W | Target output frequency in MHz |
| aux_cfg | input | 32*AUX_WORDS | Auxiliary configuration words, word i in bits 32*i+31..32*i |
| pll_lock | input | 1 | Lock flag from the PLL |
| bandgap_en | output | 1 | PLL bias enable |
| pll_rst | output | 1 | PLL reset, active high |
| pll_en | output | 1 | PLL enable |
| cfg_wr | output | 1 | Configuration write strobe |
| cfg_sel | output | SEL_W | Configuration word select: 0 main, i+1 auxiliary word i |
| cfg_data | output | 32 | Configuration write data |
| done | output | 1 | PLL locked and sequence complete |
| fail_cnt | output | FC_W | Consecutive failed lock checks |
| sys_rst_req | output | 1 | System-reset request after retry exhaustion |

## Verification
The bound checker watches the following on every cycle:
- no write occurs outside PLL reset;
- the bias enable is on whenever reset is driven;
- the failure count only steps by one or clears, and never exceeds the limit;
- the reset request is sticky and blocks writes;
- done never rises before SETTLE_US ticks have passed since the last release.

Only the bench scenarios can show that the divider fields match the target bands, that the auxiliary words arrive in order with the right data, and that the number of attempts follows the stub's lock behaviour up to and past the limit. The same holds for the restart from done and for the start pulses that must be ignored.

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq #(
  parameter int RETRY_LIMIT = 8,
  parameter int BANDGAP_US  = 100,
  parameter int SETTLE_US   = 20,
  parameter int AUX_WORDS   = 4,
  parameter int TGT_W       = 12,
  localparam int SEL_W = $clog2(AUX_WORDS + 1),
  localparam int FC_W  = $clog2(RETRY_LIMIT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   us_tick,
  input  logic [TGT_W-1:0]       target_mhz,
  input  logic [32*AUX_WORDS-1:0] aux_cfg,
  input  logic                   pll_lock,
  output logic                   bandgap_en,
  output logic                   pll_rst,
  output logic                   pll_en,
  output logic                   cfg_wr,
  output logic [SEL_W-1:0]       cfg_sel,
  output logic [31:0]            cfg_data,
  output logic                   done,
  output logic [FC_W-1:0]        fail_cnt,
  output logic                   sys_rst_req
);
  localparam int MAXW = (BANDGAP_US > SETTLE_US) ? BANDGAP_US : SETTLE_US;
  localparam int TW   = $clog2(MAXW + 1);
  localparam int IW   = (AUX_WORDS > 1) ? $clog2(AUX_WORDS) : 1;
  localparam logic [TW-1:0]   BG_LAST  = TW'(BANDGAP_US - 1);
  localparam logic [TW-1:0]   ST_LAST  = TW'(SETTLE_US - 1);
  localparam logic [IW-1:0]   AUX_LAST = IW'(AUX_WORDS - 1);
  localparam logic [FC_W-1:0] FC_LAST  = FC_W'(RETRY_LIMIT - 1);
  localparam logic [FC_W-1:0] FC_MAX   = FC_W'(RETRY_LIMIT);

  typedef enum logic [3:0] {
    S_IDLE, S_BGAP, S_RST, S_AUX, S_MAIN, S_REL, S_SETTLE, S_CHECK, S_DONE, S_HALT
  } step_t;

  step_t           step;
  logic [TW-1:0]   tcnt;
  logic [IW-1:0]   idx;
  logic [FC_W-1:0] fcnt;
  logic            bg_q, en_q;
  logic [8:0]      fld_m;
  logic [4:0]      fld_n;
  logic [1:0]      fld_od;

  always_comb begin
    fld_m = '0; fld_n = '0; fld_od = '0;
    if (target_mhz >= TGT_W'(600) && target_mhz <= TGT_W'(1200)) begin
      fld_od = 2'd1; fld_n = 5'd1; fld_m = 9'(target_mhz / TGT_W'(12));
    end else if (target_mhz > TGT_W'(1200) && target_mhz <= TGT_W'(2000)) begin
      fld_od = 2'd0; fld_n = 5'd1; fld_m = 9'(target_mhz / TGT_W'(24));
    end
  end

  wire [31:0] main_word = {1'b0, 1'b1, 1'b1, 11'd0, fld_od, 2'b00, fld_n, fld_m};

  assign bandgap_en  = bg_q;
  assign pll_en      = en_q;
  assign pll_rst     = (step == S_RST) || (step == S_AUX) || (step == S_MAIN);
  assign cfg_wr      = (step == S_AUX) || (step == S_MAIN);
  assign cfg_sel     = (step == S_AUX) ? SEL_W'(idx) + SEL_W'(1) : '0;
  assign cfg_data    = (step == S_AUX) ? aux_cfg[32*idx +: 32]
                     : (step == S_MAIN) ? main_word : '0;
  assign done        = (step == S_DONE);
  assign sys_rst_req = (step == S_HALT);
  assign fail_cnt    = fcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= S_IDLE;
      tcnt <= '0;
      idx  <= '0;
      fcnt <= '0;
      bg_q <= 1'b0;
      en_q <= 1'b0;
    end else begin
      case (step)
        S_IDLE, S_DONE:
          if (start) begin
            step <= S_BGAP;
            bg_q <= 1'b1;
            en_q <= 1'b0;
            tcnt <= '0;
          end
        S_BGAP:
          if (us_tick) begin
            if (tcnt == BG_LAST) begin
              step <= S_RST;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
        S_RST: begin
          step <= S_AUX;
          idx  <= '0;
        end
        S_AUX:
          if (idx == AUX_LAST) step <= S_MAIN;
          else idx <= idx + 1'b1;
        S_MAIN: begin
          en_q <= 1'b1;
          step <= S_REL;
        end
        S_REL: begin
          step <= S_SETTLE;
          tcnt <= '0;
        end
        S_SETTLE:
          if (us_tick) begin
            if (tcnt == ST_LAST) step <= S_CHECK;
            else tcnt <= tcnt + 1'b1;
          end
        S_CHECK:
          if (pll_lock) begin
            fcnt <= '0;
            step <= S_DONE;
          end else if (fcnt == FC_LAST) begin
            fcnt <= FC_MAX;
            step <= S_HALT;
          end else begin
            fcnt <= fcnt + 1'b1;
            step <= S_RST;
          end
        default: step <= S_HALT;
      endcase
    end
  end
endmodule

module pll_bringup_seq_chk #(
  parameter int RETRY_LIMIT = 8,
  parameter int SETTLE_US   = 20,
  parameter int FC_W        = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            us_tick,
  input logic            bandgap_en,
  input logic            pll_rst,
  input logic            pll_en,
  input logic            cfg_wr,
  input logic            done,
  input logic [FC_W-1:0] fail_cnt,
  input logic            sys_rst_req
);
  logic        rst_prev, done_prev;
  logic [15:0] since_rel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_prev  <= 1'b0;
      done_prev <= 1'b0;
      since_rel <= '0;
    end else begin
      rst_prev  <= pll_rst;
      done_prev <= done;
      if (rst_prev && !pll_rst) since_rel <= '0;
      else if (us_tick && since_rel != 16'hFFFF) since_rel <= since_rel + 1'b1;
    end
  end

  // R3
  wr_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> pll_rst);
  // R2
  bias_before_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_rst |-> bandgap_en);
  // R6
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_prev) |-> (since_rel >= 16'(SETTLE_US)));
  // R7
  fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_cnt != $past(fail_cnt)) |-> (fail_cnt == $past(fail_cnt) + 1'b1 || fail_cnt == '0));
  // R8
  done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!pll_rst && pll_en && fail_cnt == '0 && !sys_rst_req));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_cnt <= FC_W'(RETRY_LIMIT));
  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> (sys_rst_req && !cfg_wr));
endmodule

bind pll_bringup_seq pll_bringup_seq_chk #(
  .RETRY_LIMIT(RETRY_LIMIT), .SETTLE_US(SETTLE_US), .FC_W(FC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .bandgap_en(bandgap_en),
  .pll_rst(pll_rst), .pll_en(pll_en), .cfg_wr(cfg_wr), .done(done),
  .fail_cnt(fail_cnt), .sys_rst_req(sys_rst_req)
);

// File: tb/pll_bringup_seq_bench.sv
`timescale 1ns/1ps
module pll_bringup_seq_bench;
  localparam int LIMIT = 8;
  localparam int BG    = 100;
  localparam int ST    = 20;
  localparam int AUX   = 4;
  localparam int SW    = $clog2(AUX + 1);
  localparam int FW    = $clog2(LIMIT + 1);
  localparam int NV    = 6;
  // target, fails before lock, M, N, OD, halt expected
  localparam int VT[NV] = '{1000,  600, 1200, 1536, 2000, 500};
  localparam int VF[NV] = '{   0,    2,    0,    7,    8,   0};
  localparam int VM[NV] = '{  83,   50,  100,   64,   83,   0};
  localparam int VN[NV] = '{   1,    1,    1,    1,    1,   0};
  localparam int VO[NV] = '{   1,    1,    1,    0,    0,   0};
  localparam int VH[NV] = '{   0,    0,    0,    0,    1,   0};

  logic clk = 0, rst_n = 0, start = 0, us_tick = 0;
  logic [11:0] target_mhz = '0;
  logic [32*AUX-1:0] aux_cfg;
  logic pll_lock;
  logic bandgap_en, pll_rst, pll_en, cfg_wr, done, sys_rst_req;
  logic [SW-1:0] cfg_sel;
  logic [31:0] cfg_data;
  logic [FW-1:0] fail_cnt;

  int checks = 0, failures = 0;
  int fails_before_lock = 0;
  int rels = 0, aux_wr = 0, main_wr = 0, order_err = 0, aux_pos = 0;
  int bg_ticks = 0, bg_at_rst = -1, since_rel = 0, settle_min = 1000000;
  logic [31:0] last_main = '0;
  logic prev_rst = 0, prev_done = 0;

  always #4 clk = ~clk;

  initial begin
    for (int i = 0; i < AUX; i++) aux_cfg[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 3 + 1);
  end

  initial forever begin
    repeat (4) @(negedge clk);
    us_tick = 1;
    @(negedge clk);
    us_tick = 0;
  end

  assign pll_lock = !pll_rst && pll_en && (rels > fails_before_lock);

  pll_bringup_seq #(.RETRY_LIMIT(LIMIT), .BANDGAP_US(BG), .SETTLE_US(ST), .AUX_WORDS(AUX))
  u_pll_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick), .target_mhz(target_mhz),
    .aux_cfg(aux_cfg), .pll_lock(pll_lock), .bandgap_en(bandgap_en), .pll_rst(pll_rst),
    .pll_en(pll_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .done(done),
    .fail_cnt(fail_cnt), .sys_rst_req(sys_rst_req)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_wr) begin
        if (!pll_rst) order_err++;
        if (cfg_sel == '0) begin
          main_wr++; last_main = cfg_data;
          if (aux_pos != 0) order_err++;
        end else begin
          if (int'(cfg_sel) != aux_pos + 1 || cfg_data != aux_cfg[32*aux_pos +: 32]) order_err++;
          aux_wr++; aux_pos = (aux_pos + 1) % AUX;
        end
      end
      if (prev_rst && !pll_rst) begin rels++; since_rel = 0; end
      else if (us_tick) since_rel++;
      if (!prev_rst && pll_rst && bg_at_rst < 0) bg_at_rst = bg_ticks;
      if (us_tick && bandgap_en && bg_at_rst < 0) bg_ticks++;
      if (done && !prev_done && since_rel < settle_min) settle_min = since_rel;
      prev_rst = pll_rst; prev_done = done;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    rels = 0; aux_wr = 0; main_wr = 0; order_err = 0; aux_pos = 0;
    bg_ticks = 0; bg_at_rst = -1; settle_min = 1000000;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    prev_rst = 0; prev_done = 0;
    clear_mon();
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_end(output bit timed_out);
    timed_out = 1;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done || sys_rst_req) begin timed_out = 0; break; end
    end
  endtask

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit to;
    int exp_rel;
    for (int v = 0; v < NV; v++) begin
      do_reset();
      // R1
      check({bandgap_en, pll_rst, pll_en, cfg_wr, done, sys_rst_req} == 6'b0 && fail_cnt == 0,
            "R1 reset outputs", int'({bandgap_en, pll_rst, pll_en, cfg_wr, done, sys_rst_req}), 0);
      target_mhz = 12'(VT[v]);
      fails_before_lock = VF[v];
      pulse_start();
      wait_end(to);
      check(!to, "R8/R9 sequence ended", int'(to), 0);
      exp_rel = VH[v] ? LIMIT : VF[v] + 1;
      if (VH[v]) begin
        check(sys_rst_req && !done, "R9 reset request", int'(sys_rst_req), 1);
        check(int'(fail_cnt) == LIMIT, "R9 fail_cnt at limit", int'(fail_cnt), LIMIT);
      end else begin
        check(done && !sys_rst_req, "R8 done", int'(done), 1);
        check(fail_cnt == 0 && pll_en && !pll_rst, "R8 counter cleared", int'(fail_cnt), 0);
        check(settle_min >= ST, "R6 settle wait", settle_min, ST);
      end
      check(rels == exp_rel, "R7 attempts", rels, exp_rel);
      check(main_wr == exp_rel && aux_wr == AUX * exp_rel, "R7 full rewrite", aux_wr, AUX * exp_rel);
      check(order_err == 0, "R3 write order and data", order_err, 0);
      check(bg_at_rst >= BG, "R2 bias wait", bg_at_rst, BG);
      check(last_main[31:29] == 3'b011, "R4 flag bits", int'(last_main[31:29]), 3);
      check(int'(last_main[8:0]) == VM[v], "R5 M field", int'(last_main[8:0]), VM[v]);
      check(int'(last_main[13:9]) == VN[v], "R5 N field", int'(last_main[13:9]), VN[v]);
      check(int'(last_main[17:16]) == VO[v], "R5 OD field", int'(last_main[17:16]), VO[v]);
    end

    // R9: start after halt is ignored, no writes
    do_reset();
    target_mhz = 12'd1000; fails_before_lock = 100;
    pulse_start(); wait_end(to);
    clear_mon();
    pulse_start();
    repeat (300) @(negedge clk);
    check(sys_rst_req && !done, "R9 halt sticky", int'(sys_rst_req), 1);
    check(main_wr == 0 && aux_wr == 0, "R9 no writes after halt", main_wr + aux_wr, 0);

    // R10: start mid-sequence ignored, start after done reruns from bias wait
    do_reset();
    target_mhz = 12'd800; fails_before_lock = 0;
    pulse_start();
    repeat (50) @(negedge clk);
    pulse_start();
    wait_end(to);
    check(done && rels == 1, "R10 busy start ignored", rels, 1);
    fails_before_lock = 1;
    clear_mon();
    pulse_start();
    check(!done, "R10 restart leaves done", int'(done), 0);
    wait_end(to);
    check(done && rels == 2, "R10 restart attempts", rels, 2);
    check(bg_at_rst >= BG, "R10 restart bias wait", bg_at_rst, BG);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule